// File: doc/BRIEF.md
# Packet-to-Cell Segmenter with Multi-Link Spraying

This block sits at the output of an ingress queue, after a packet has been granted a transmission slot toward its egress processor. The packet arrives as a byte stream, one byte per accepted beat, with start and end markers. The block collects the bytes into cells of at most `CELL_BYTES` bytes. Every cell is full-sized except the last cell of a packet, which carries only the remaining bytes. Each cell is handed to one of `N_LINKS` parallel fabric links.

A rotating pointer picks the link for each cell. The pointer skips links that are switched off in the active-link mask and links whose output slot is still occupied, so the cells of one packet spread across every usable link at once. Each cell travels with a header: the destination processor, a cell sequence number that restarts at zero for every packet, first and last flags, and the payload byte count. With this header the far end can put the packet back together in order. A link whose receiver holds its ready low keeps its own cell and stalls only itself.

Top module: `cell_sprayer`

## Requirements
- R1: Every cell carries between 1 and `CELL_BYTES` payload bytes. Every cell except the last of a packet carries exactly `CELL_BYTES`, and the last carries the remainder.
- R2: Each cell header is 26 bits. Bits [8:0] hold the payload byte count, bit 9 the last flag, bit 10 the first flag, bits [18:11] the cell sequence number and bits [25:19] the 7-bit destination index. The destination index is captured from `in_dest` on the start beat. The sequence number is 0 for a packet's first cell and rises by one per cell. The first flag is set only on sequence 0, and the last flag only on the cell holding the end-marked byte.
- R3: While all links are free, successive cells go to successive active links in ascending index order, wrapping from the top index to 0. The pointer continues across packet boundaries and starts at link 0 after reset. At most one new cell is loaded onto the links per cycle.
- R4: A cell is never loaded onto a link whose bit in `link_mask` is 0 in the cycle of loading.
- R5: A link holding a cell with its ready low keeps `cell_valid` high and its header and payload unchanged. Other links keep receiving cells, and the busy link is skipped.
- R6: While `link_mask` is all zero, `in_ready` is low and no new cell is emitted.
- R7: A start-marked beat arriving between packets is accepted only while `pkt_grant` is high. Later beats of a packet that has started are accepted regardless of `pkt_grant`.
- R8: After reset all `cell_valid` outputs are low, and `in_ready` is high only when `pkt_grant` is high and at least one link is active.
- R9: Payload byte j of a cell sits at bits [8j+7:8j] of that link's `cell_data` slice. Placing each cell at offset sequence × `CELL_BYTES` rebuilds the original packet byte for byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| link_mask | input | N_LINKS | 1 marks a fabric link as usable |
| pkt_grant | input | 1 | Transmission grant for the next packet |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_sop | input | 1 | Beat is the first byte of a packet |
| in_eop | input | 1 | Beat is the last byte of a packet |
| in_dest | input | 7 | Destination processor index, read on the start beat |
| in_data | input | 8 | Packet byte |
| cell_valid | output | N_LINKS | Per-link cell present |
| cell_ready | input | N_LINKS | Per-link cell taken |
| cell_hdr | output | N_LINKS*26 | Per-link header, link i at bits [26i+25:26i] |
| cell_data | output | N_LINKS*CELL_BYTES*8 | Per-link payload, link i at slice i of CELL_BYTES*8 bits |

## Verification
The bench goes after the following corner cases:
- Packet lengths of one byte, exactly one cell, one byte over a cell, and several cells. A wrong remainder count or a dropped final cell would make reassembly fail.
- The link sequence under a full mask and under a sparse mask. A pointer that resets per packet or does not skip dark links would send cells to the wrong or inactive links.
- An all-zero mask, and a missing grant on a start beat. In both cases the input must stay blocked, and a design that leaked a byte would emit cells early.
- One link held not-ready across two packets. A design that stalled globally would never finish the second packet, and a design that overwrote the parked cell would change its header.

// File: rtl/spray_pkg.sv
package spray_pkg;
    localparam int DEST_W = 7;
    localparam int SEQ_W  = 8;
    localparam int CNT_W  = 9;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic [SEQ_W-1:0]  seq;
        logic              first;
        logic              last;
        logic [CNT_W-1:0]  cnt;
    } cell_hdr_t;

    localparam int HDR_W = $bits(cell_hdr_t);
endpackage

// File: rtl/cell_assembler.sv
module cell_assembler
    import spray_pkg::*;
#(
    parameter int CELL_BYTES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       in_sop,
    input  logic                       in_eop,
    input  logic [DEST_W-1:0]          in_dest,
    input  logic [7:0]                 in_data,
    input  logic                       pkt_grant,
    input  logic                       links_up,
    input  logic                       take,
    output logic                       in_ready,
    output logic                       pend,
    output cell_hdr_t                  hdr,
    output logic [CELL_BYTES*8-1:0]    payload
);
    localparam int PAY_W = CELL_BYTES * 8;

    typedef struct packed {
        logic [PAY_W-1:0]  pay;
        logic [CNT_W-1:0]  cnt;
        logic [SEQ_W-1:0]  seq;
        logic [DEST_W-1:0] dest;
        logic              first;
        logic              last;
        logic              pend;
        logic              inpkt;
    } asm_state_t;

    asm_state_t state_d, state_q;
    logic       accept;
    logic [CNT_W-1:0] wr_pos;

    assign in_ready = !state_q.pend && links_up && (state_q.inpkt || pkt_grant);
    assign accept   = in_valid && in_ready;

    always_comb begin
        state_d = state_q;
        wr_pos  = state_q.cnt;
        if (take) begin
            state_d.pend  = 1'b0;
            state_d.cnt   = '0;
            state_d.first = 1'b0;
            state_d.seq   = state_q.seq + SEQ_W'(1);
            if (state_q.last) begin
                state_d.inpkt = 1'b0;
            end
        end
        if (accept) begin
            if (in_sop) begin
                state_d.dest  = in_dest;
                state_d.seq   = '0;
                state_d.first = 1'b1;
                state_d.inpkt = 1'b1;
                wr_pos        = '0;
            end
            state_d.pay[int'(wr_pos)*8 +: 8] = in_data;
            state_d.cnt = wr_pos + CNT_W'(1);
            if ((int'(wr_pos) + 1 == CELL_BYTES) || in_eop) begin
                state_d.pend = 1'b1;
                state_d.last = in_eop;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pend      = state_q.pend;
    assign payload   = state_q.pay;
    assign hdr.dest  = state_q.dest;
    assign hdr.seq   = state_q.seq;
    assign hdr.first = state_q.first;
    assign hdr.last  = state_q.last;
    assign hdr.cnt   = state_q.cnt;
endmodule

// File: rtl/link_picker.sv
module link_picker #(
    parameter int N_LINKS = 4,
    localparam int PTR_W  = (N_LINKS > 1) ? $clog2(N_LINKS) : 1
) (
    input  logic [PTR_W-1:0]   ptr,
    input  logic [N_LINKS-1:0] mask,
    input  logic [N_LINKS-1:0] free,
    output logic               found,
    output logic [PTR_W-1:0]   sel
);
    always_comb begin
        found = 1'b0;
        sel   = '0;
        // scan from the farthest candidate down so the nearest one wins
        for (int k = N_LINKS - 1; k >= 0; k--) begin
            int idx;
            idx = int'(ptr) + k;
            if (idx >= N_LINKS) begin
                idx = idx - N_LINKS;
            end
            if (mask[idx] && free[idx]) begin
                found = 1'b1;
                sel   = PTR_W'(idx);
            end
        end
    end
endmodule

// File: rtl/link_slot.sv
module link_slot
    import spray_pkg::*;
#(
    parameter int PAY_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  cell_hdr_t        hdr_in,
    input  logic [PAY_W-1:0] pay_in,
    input  logic             ready,
    output logic             valid,
    output cell_hdr_t        hdr,
    output logic [PAY_W-1:0] pay,
    output logic             free
);
    typedef struct packed {
        logic             valid;
        cell_hdr_t        hdr;
        logic [PAY_W-1:0] pay;
    } slot_state_t;

    slot_state_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.valid && ready) begin
            slot_d.valid = 1'b0;
        end
        if (load) begin
            slot_d.valid = 1'b1;
            slot_d.hdr   = hdr_in;
            slot_d.pay   = pay_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign valid = slot_q.valid;
    assign hdr   = slot_q.hdr;
    assign pay   = slot_q.pay;
    assign free  = !slot_q.valid || ready;
endmodule

// File: rtl/cell_sprayer.sv
module cell_sprayer
    import spray_pkg::*;
#(
    parameter int N_LINKS    = 4,
    parameter int CELL_BYTES = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_LINKS-1:0]              link_mask,
    input  logic                            pkt_grant,
    input  logic                            in_valid,
    output logic                            in_ready,
    input  logic                            in_sop,
    input  logic                            in_eop,
    input  logic [DEST_W-1:0]               in_dest,
    input  logic [7:0]                      in_data,
    output logic [N_LINKS-1:0]              cell_valid,
    input  logic [N_LINKS-1:0]              cell_ready,
    output logic [N_LINKS*HDR_W-1:0]        cell_hdr,
    output logic [N_LINKS*CELL_BYTES*8-1:0] cell_data
);
    localparam int PAY_W = CELL_BYTES * 8;
    localparam int PTR_W = (N_LINKS > 1) ? $clog2(N_LINKS) : 1;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } top_state_t;

    top_state_t top_d, top_q;

    logic             pend;
    logic             take;
    logic             found;
    logic [PTR_W-1:0] sel;
    cell_hdr_t        asm_hdr;
    logic [PAY_W-1:0] asm_pay;
    logic [N_LINKS-1:0] slot_free;
    logic [N_LINKS-1:0] load;

    cell_assembler #(.CELL_BYTES(CELL_BYTES)) i_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_dest   (in_dest),
        .in_data   (in_data),
        .pkt_grant (pkt_grant),
        .links_up  (|link_mask),
        .take      (take),
        .in_ready  (in_ready),
        .pend      (pend),
        .hdr       (asm_hdr),
        .payload   (asm_pay)
    );

    link_picker #(.N_LINKS(N_LINKS)) i_pick (
        .ptr   (top_q.ptr),
        .mask  (link_mask),
        .free  (slot_free),
        .found (found),
        .sel   (sel)
    );

    assign take = pend && found;

    always_comb begin
        top_d = top_q;
        if (take) begin
            top_d.ptr = (int'(sel) == N_LINKS - 1) ? '0 : sel + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    for (genvar g = 0; g < N_LINKS; g++) begin : g_link
        cell_hdr_t slot_hdr;

        assign load[g] = take && (sel == PTR_W'(g));

        link_slot #(.PAY_W(PAY_W)) i_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load[g]),
            .hdr_in (asm_hdr),
            .pay_in (asm_pay),
            .ready  (cell_ready[g]),
            .valid  (cell_valid[g]),
            .hdr    (slot_hdr),
            .pay    (cell_data[g*PAY_W +: PAY_W]),
            .free   (slot_free[g])
        );

        assign cell_hdr[g*HDR_W +: HDR_W] = slot_hdr;
    end
endmodule

// File: rtl/spray_checker.sv
module spray_checker
    import spray_pkg::*;
#(
    parameter int N_LINKS    = 4,
    parameter int CELL_BYTES = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_LINKS-1:0]       link_mask,
    input logic                     in_ready,
    input logic [N_LINKS-1:0]       cell_valid,
    input logic [N_LINKS-1:0]       cell_ready,
    input logic [N_LINKS*HDR_W-1:0] cell_hdr
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(CELL_BYTES);

    logic [N_LINKS-1:0] was_free_q;
    logic [N_LINKS-1:0] fresh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            was_free_q <= '1;
        end else begin
            was_free_q <= ~cell_valid | cell_ready;
        end
    end

    assign fresh = cell_valid & was_free_q;

    assert_dark_blocks_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (link_mask == '0) |-> !in_ready);

    assert_single_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fresh) <= 1);

    for (genvar i = 0; i < N_LINKS; i++) begin : g_chk
        cell_hdr_t hv;
        assign hv = cell_hdr[i*HDR_W +: HDR_W];

        assert_stall_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (cell_valid[i] && !cell_ready[i]) |=>
                (cell_valid[i] && $stable(cell_hdr[i*HDR_W +: HDR_W])));

        assert_active_link_R4: assert property (@(posedge clk) disable iff (!rst_n)
            fresh[i] |-> $past(link_mask[i]));

        assert_cell_size_R1: assert property (@(posedge clk) disable iff (!rst_n)
            cell_valid[i] |-> (hv.cnt != '0 && hv.cnt <= FULL && (hv.last || hv.cnt == FULL)));

        assert_first_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
            cell_valid[i] |-> (hv.first == (hv.seq == '0)));
    end
endmodule

bind cell_sprayer spray_checker #(
    .N_LINKS    (N_LINKS),
    .CELL_BYTES (CELL_BYTES)
) i_spray_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_mask  (link_mask),
    .in_ready   (in_ready),
    .cell_valid (cell_valid),
    .cell_ready (cell_ready),
    .cell_hdr   (cell_hdr)
);

// File: tb/test_cell_sprayer.sv
module test_cell_sprayer;
    import spray_pkg::*;

    localparam int NL = 5;
    localparam int CB = 8;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [NL-1:0]          link_mask = '1;
    logic                   pkt_grant = 1'b0;
    logic                   in_valid = 1'b0;
    logic                   in_ready;
    logic                   in_sop = 1'b0;
    logic                   in_eop = 1'b0;
    logic [DEST_W-1:0]      in_dest = '0;
    logic [7:0]             in_data = '0;
    logic [NL-1:0]          cell_valid;
    logic [NL-1:0]          cell_ready = '1;
    logic [NL*HDR_W-1:0]    cell_hdr;
    logic [NL*CB*8-1:0]     cell_data;

    int n_chk = 0;
    int n_err = 0;

    logic [7:0] exp_buf [128][64];
    int         exp_len [128];
    logic [7:0] rx_buf  [128][64];
    int         rx_cells[128];
    int         rx_lastseq[128];
    bit         got_last[128];
    int         rx_total[128];
    bit         done[128];
    int         link_log[$];
    int         exp_links[$];
    int         bptr = 0;

    always #10 clk = ~clk;

    cell_sprayer #(.N_LINKS(NL), .CELL_BYTES(CB)) i_cell_sprayer (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_mask  (link_mask),
        .pkt_grant  (pkt_grant),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_sop     (in_sop),
        .in_eop     (in_eop),
        .in_dest    (in_dest),
        .in_data    (in_data),
        .cell_valid (cell_valid),
        .cell_ready (cell_ready),
        .cell_hdr   (cell_hdr),
        .cell_data  (cell_data)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: records every transferred cell and rebuilds packets by sequence
    task automatic take_cell(input int i);
        cell_hdr_t h;
        int d;
        h = cell_hdr[i*HDR_W +: HDR_W];
        d = int'(h.dest);
        link_log.push_back(i);
        chk(h.cnt >= 1 && h.cnt <= CB && (h.last || h.cnt == CB), "R1", "cell byte count",
            int'(h.cnt), CB);
        chk(h.first == (h.seq == 0), "R2", "first flag vs seq", int'(h.first), int'(h.seq == 0));
        chk(exp_len[d] != 0, "R2", "destination field names a sent packet", d, d);
        chk(link_mask[i] == 1'b1, "R4", "cell on inactive link", i, -1);
        for (int j = 0; j < int'(h.cnt); j++) begin
            int pos;
            pos = int'(h.seq) * CB + j;
            if (pos < 64) rx_buf[d][pos] = cell_data[i*CB*8 + j*8 +: 8];
        end
        rx_cells[d]++;
        if (h.last) begin
            got_last[d]   = 1'b1;
            rx_lastseq[d] = int'(h.seq);
            rx_total[d]   = int'(h.seq) * CB + int'(h.cnt);
        end
        if (got_last[d] && rx_cells[d] == rx_lastseq[d] + 1 && !done[d]) begin
            int bad;
            bad = 0;
            for (int j = 0; j < exp_len[d] && j < 64; j++)
                if (rx_buf[d][j] !== exp_buf[d][j]) bad++;
            chk(rx_total[d] == exp_len[d], "R9", "reassembled length", rx_total[d], exp_len[d]);
            chk(bad == 0, "R9", "reassembled byte mismatches", bad, 0);
            done[d] = 1'b1;
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NL; i++)
                if (cell_valid[i] && cell_ready[i]) take_cell(i);
        end
    end

    task automatic send_pkt(input int dest, input int len, input bit drop_grant);
        exp_len[dest] = len;
        for (int b = 0; b < len; b++) begin
            logic [7:0] v;
            v = 8'(dest * 29 + b * 7 + 3);
            exp_buf[dest][b] = v;
            in_valid = 1'b1;
            in_data  = v;
            in_sop   = (b == 0);
            in_eop   = (b == len - 1);
            in_dest  = DEST_W'(dest);
            do @(negedge clk); while (!in_ready);
            @(posedge clk);
            #1;
            if (drop_grant && b == 0) pkt_grant = 1'b0;
        end
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
    endtask

    task automatic wait_done(input int dest);
        while (!done[dest]) @(posedge clk);
        #1;
    endtask

    task automatic model_links(input int ncells, input logic [NL-1:0] m);
        for (int c = 0; c < ncells; c++) begin
            while (!m[bptr]) bptr = (bptr + 1) % NL;
            exp_links.push_back(bptr);
            bptr = (bptr + 1) % NL;
        end
    endtask

    task automatic compare_links(input string req);
        int bad;
        bad = 0;
        for (int k = 0; k < exp_links.size(); k++)
            if (k >= link_log.size() || link_log[k] != exp_links[k]) bad++;
        chk(link_log.size() == exp_links.size(), req, "cells in link order log",
            link_log.size(), exp_links.size());
        chk(bad == 0, req, "link order mismatches", bad, 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        // R8: reset state, grant low
        @(negedge clk);
        chk(cell_valid == '0, "R8", "cell_valid after reset", int'(cell_valid), 0);
        chk(in_ready == 1'b0, "R8", "in_ready without grant", int'(in_ready), 0);
        @(posedge clk); #1 pkt_grant = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R8", "in_ready with grant and links", int'(in_ready), 1);
        @(posedge clk); #1;

        // R1 R2 R3 R9: various lengths, full mask, all links free
        link_log.delete(); exp_links.delete();
        send_pkt(1, 1, 1'b0);  model_links(1, link_mask);
        send_pkt(2, 8, 1'b0);  model_links(1, link_mask);
        send_pkt(3, 9, 1'b0);  model_links(2, link_mask);
        send_pkt(4, 17, 1'b0); model_links(3, link_mask);
        send_pkt(5, 40, 1'b0); model_links(5, link_mask);
        for (int p = 1; p <= 5; p++) wait_done(p);
        compare_links("R3");

        // R3 R4: sparse mask, pointer carried over
        link_mask = 5'b10101;
        link_log.delete(); exp_links.delete();
        send_pkt(6, 33, 1'b0); model_links(5, link_mask);
        wait_done(6);
        compare_links("R4");

        // R6: no active links
        link_mask = '0;
        link_log.delete();
        begin
            bit saw_ready;
            saw_ready = 1'b0;
            in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b0; in_dest = 7'd7; in_data = 8'h55;
            repeat (20) begin
                @(negedge clk);
                if (in_ready) saw_ready = 1'b1;
            end
            chk(!saw_ready, "R6", "in_ready with empty mask", int'(saw_ready), 0);
            chk(link_log.size() == 0, "R6", "cells with empty mask", link_log.size(), 0);
            @(posedge clk); #1;
        end
        link_mask = '1;
        send_pkt(7, 12, 1'b0);
        wait_done(7);

        // R7: start beat blocked without grant, later beats pass without it
        pkt_grant = 1'b0;
        begin
            bit saw_ready;
            saw_ready = 1'b0;
            in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b0; in_dest = 7'd8; in_data = 8'hAA;
            repeat (12) begin
                @(negedge clk);
                if (in_ready) saw_ready = 1'b1;
            end
            chk(!saw_ready, "R7", "start beat accepted without grant", int'(saw_ready), 0);
            @(posedge clk); #1;
        end
        pkt_grant = 1'b1;
        send_pkt(8, 20, 1'b1);
        wait_done(8);
        chk(done[8], "R7", "packet finished after grant dropped", int'(done[8]), 1);
        pkt_grant = 1'b1;

        // R5: link 1 stalled, others continue across two packets
        cell_ready = 5'b11101;
        send_pkt(9, 40, 1'b0);
        repeat (3) @(posedge clk);
        #1;
        begin
            logic [HDR_W-1:0] snap;
            snap = cell_hdr[1*HDR_W +: HDR_W];
            chk(cell_valid[1] == 1'b1, "R5", "stalled link keeps valid", int'(cell_valid[1]), 1);
            repeat (20) @(posedge clk);
            #1;
            chk(cell_valid[1] == 1'b1 && cell_hdr[1*HDR_W +: HDR_W] == snap, "R5",
                "stalled header unchanged", int'(cell_hdr[1*HDR_W +: HDR_W]), int'(snap));
            chk(rx_cells[9] == 4, "R5", "other cells of stalled packet delivered", rx_cells[9], 4);
        end
        send_pkt(10, 40, 1'b0);
        wait_done(10);
        chk(cell_valid[1] == 1'b1, "R5", "busy link skipped for next packet", int'(cell_valid[1]), 1);
        cell_ready = '1;
        wait_done(9);
        chk(done[9], "R5", "stalled packet completes after release", int'(done[9]), 1);

        repeat (5) @(posedge clk);
        finish_run();
    end
endmodule